// File: doc/BRIEF.md
# Interrupt steering aggregator

The block collects a parameterised set of level-sensitive interrupt inputs, from 32 to 512 in steps of 32, and reduces them to one output line per group of 64 inputs. Each input has an enable bit and a software force bit. The block reports a live per-input pending status that is never latched. Software reaches a small register file over a simple word-addressed bus. Through it, software steers the block to a channel, enables or forces individual inputs, reads their pending state, blocks any output line and reads each group's summary before that block is applied.

Let R = NUM_IRQS/32. Each bank of 32-bit words holds R words. Within a bank the words run in reverse order, so the word at the lowest offset carries the highest-numbered 32 inputs. The banks are spaced by a stride of 4R bytes. The output lines are registered.

Top module: `irq_steer_hub`

## Requirements
- R1: After reset, every register reads zero and every output line is low.
- R2: Addressing uses byte offsets on 32-bit words. The control word is at 0x0. Enable word n is at 0x4+4n. Force word n is at 4R+0x4+4n. Status word n is at 8R+0x4+4n. The block word is at 12R+0x4 and the group summary word is at 12R+0x8. In all three banks, input k sits in word R-1-floor(k/32) at bit k mod 32.
- R3: The enable words, force words, block word and control word can be written and read back. The block word keeps bits 0..NOUT-1 and reads zero above them.
- R4: Status bit k equals (input k OR force bit k) AND enable bit k, where an enable of 1 enables the input. It follows the input level with no latching.
- R5: Output line j goes high one clock after any status bit in inputs 64j to 64j+63 is set, provided the other gating conditions allow it. There are ceil(NUM_IRQS/64) output lines.
- R6: A 1 in bit j of the block word holds output j low. Bit j of the group summary word shows whether group j has any status bit set, regardless of the block word.
- R7: Output lines can go high only while bit CHAN_IDX of the control word is 1.
- R8: A read of any offset that is not mapped returns zero. Writes to the status words and to the group summary word have no effect.
- R9: Read data is presented on the clock after rd_en and reflects the register state before a write in that same cycle. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IRQS | Level interrupt inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_out | output | NOUT | Aggregated output lines, one per 64 inputs |

## Verification
The assertions check three rules on every cycle. No output line goes high unless the channel bit was set and the group summary was set one cycle earlier. A blocked line stays low. Read data moves only after a read strobe.

Some behaviour can only be shown by the bench's scenarios against its reference model. This covers the reverse word ordering and the bank strides, and the level-following status with its force and enable terms. It also covers the ignored writes to read-only words, the zero returned for unmapped offsets, and the read-before-write ordering.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
   localparam int WORD_W  = 32;
   localparam int GROUP_W = 64;
   localparam int MAX_IRQ = 512;

   typedef enum logic [2:0] {
      RG_CTRL, RG_EN, RG_FRC, RG_STAT, RG_BLK, RG_SUM, RG_NONE
   } region_t;

   // Word n of a bank carries input group (nreg-1-n).
   function automatic int grp_of_word(input int nreg, input int n);
      return nreg - 1 - n;
   endfunction
endpackage

// File: rtl/irq_steer_status.sv
module irq_steer_status #(
   parameter int NUM_IRQS = 128,
   parameter int NOUT     = 2
) (
   input  logic [NUM_IRQS-1:0] irq_in,
   input  logic [NUM_IRQS-1:0] en_q,
   input  logic [NUM_IRQS-1:0] frc_q,
   output logic [NUM_IRQS-1:0] status,
   output logic [NOUT-1:0]     grp_any
);
   import irq_steer_pkg::*;

   assign status = (irq_in | frc_q) & en_q;

   for (genvar j = 0; j < NOUT; j++) begin : g_grp
      localparam int LO = j * GROUP_W;
      localparam int WD = (NUM_IRQS - LO < GROUP_W) ? (NUM_IRQS - LO) : GROUP_W;
      assign grp_any[j] = |status[LO +: WD];
   end
endmodule

// File: rtl/irq_steer_regs.sv
module irq_steer_regs #(
   parameter int NUM_IRQS = 128,
   parameter int NOUT     = 2,
   parameter int ADDR_W   = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [31:0]         wdata,
   input  logic [NUM_IRQS-1:0] status,
   input  logic [NOUT-1:0]     grp_any,
   output logic [NUM_IRQS-1:0] en_q,
   output logic [NUM_IRQS-1:0] frc_q,
   output logic [NOUT-1:0]     blk_q,
   output logic [31:0]         ctrl_q,
   output logic [31:0]         rdata
);
   import irq_steer_pkg::*;

   localparam int NREG = NUM_IRQS / WORD_W;

   region_t     region;
   int          sel;
   int          wnum;
   logic [31:0] rd_word;

   always_comb begin
      wnum   = int'(addr[ADDR_W-1:2]);
      region = RG_NONE;
      sel    = 0;
      if (addr[1:0] != 2'b00) begin
         region = RG_NONE;
      end else if (wnum == 0) begin
         region = RG_CTRL;
      end else if (wnum <= NREG) begin
         region = RG_EN;
         sel    = wnum - 1;
      end else if (wnum <= 2 * NREG) begin
         region = RG_FRC;
         sel    = wnum - 1 - NREG;
      end else if (wnum <= 3 * NREG) begin
         region = RG_STAT;
         sel    = wnum - 1 - 2 * NREG;
      end else if (wnum == 3 * NREG + 1) begin
         region = RG_BLK;
      end else if (wnum == 3 * NREG + 2) begin
         region = RG_SUM;
      end
   end

   always_comb begin
      unique case (region)
         RG_CTRL: rd_word = ctrl_q;
         RG_EN:   rd_word = en_q[grp_of_word(NREG, sel)*WORD_W +: WORD_W];
         RG_FRC:  rd_word = frc_q[grp_of_word(NREG, sel)*WORD_W +: WORD_W];
         RG_STAT: rd_word = status[grp_of_word(NREG, sel)*WORD_W +: WORD_W];
         RG_BLK:  rd_word = 32'(blk_q);
         RG_SUM:  rd_word = 32'(grp_any);
         default: rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         en_q   <= '0;
         frc_q  <= '0;
         blk_q  <= '0;
      end else if (wr_en) begin
         case (region)
            RG_CTRL: ctrl_q <= wdata;
            RG_EN:   en_q[grp_of_word(NREG, sel)*WORD_W +: WORD_W]  <= wdata;
            RG_FRC:  frc_q[grp_of_word(NREG, sel)*WORD_W +: WORD_W] <= wdata;
            RG_BLK:  blk_q <= wdata[NOUT-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_word;
   end

   // R9: read data only moves after a read strobe
   a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_en) |-> $stable(rdata));
endmodule

// File: rtl/irq_steer_hub.sv
module irq_steer_hub #(
   parameter int NUM_IRQS = 128,
   parameter int CHAN_IDX = 3,
   parameter int ADDR_W   = 12,
   localparam int NOUT    = (NUM_IRQS + 63) / 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_IRQS-1:0] irq_in,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [31:0]         wdata,
   output logic [31:0]         rdata,
   output logic [NOUT-1:0]     irq_out
);
   import irq_steer_pkg::*;

   localparam int NREG = NUM_IRQS / WORD_W;

   if (NUM_IRQS < WORD_W || NUM_IRQS > MAX_IRQ || (NUM_IRQS % WORD_W) != 0) begin : g_bad_num
      $error("NUM_IRQS must be a multiple of 32 between 32 and 512");
   end
   if (CHAN_IDX < 0 || CHAN_IDX > 31) begin : g_bad_chan
      $error("CHAN_IDX must lie in 0..31");
   end
   if ((3 * NREG + 3) * 4 > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_IRQS-1:0] en_q, frc_q, status;
   logic [NOUT-1:0]     blk_q, grp_any;
   logic [31:0]         ctrl_q;
   logic                chan_on;

   irq_steer_regs #(.NUM_IRQS(NUM_IRQS), .NOUT(NOUT), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .status(status), .grp_any(grp_any), .en_q(en_q),
      .frc_q(frc_q), .blk_q(blk_q), .ctrl_q(ctrl_q), .rdata(rdata)
   );

   irq_steer_status #(.NUM_IRQS(NUM_IRQS), .NOUT(NOUT)) u_stat (
      .irq_in(irq_in), .en_q(en_q), .frc_q(frc_q),
      .status(status), .grp_any(grp_any)
   );

   assign chan_on = ctrl_q[CHAN_IDX];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out <= '0;
      else        irq_out <= grp_any & ~blk_q & {NOUT{chan_on}};
   end

   // R1: registers come out of reset cleared
   a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> (irq_out == '0 && rdata == '0));
   // R7: a line rises only when the channel was selected
   a_r7_chan_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_out) |-> $past(chan_on));
   // R6: a blocked line stays low
   a_r6_block_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & $past(blk_q)) == '0);
   // R5: a line rises only over a group with pending status
   a_r5_needs_group: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~$past(grp_any)) == '0);
endmodule

// File: tb/irq_steer_hub_tb.sv
module irq_steer_hub_tb;
   localparam int NUM  = 128;
   localparam int CH   = 3;
   localparam int AW   = 12;
   localparam int NO   = (NUM + 63) / 64;
   localparam int R    = NUM / 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NUM-1:0]  irq_in = '0;
   logic            wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [31:0]     wdata = '0;
   logic [31:0]     rdata;
   logic [NO-1:0]   irq_out;

   int checks = 0, fails = 0;
   string cur_req = "R1";
   bit done = 0;

   // reference state
   logic [NUM-1:0] m_en = '0, m_frc = '0;
   logic [31:0]    m_ctrl = '0;
   logic [NO-1:0]  m_blk = '0;
   logic [NO-1:0]  e_out = '0;
   logic [31:0]    e_rd = '0;

   always #4 clk = ~clk;

   irq_steer_hub #(.NUM_IRQS(NUM), .CHAN_IDX(CH), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out));

   function automatic bit stat_bit(int k);
      return (irq_in[k] | m_frc[k]) & m_en[k];
   endfunction

   function automatic bit grp_bit(int j);
      bit any = 0;
      for (int k = j * 64; k < j * 64 + 64 && k < NUM; k++) any |= stat_bit(k);
      return any;
   endfunction

   function automatic logic [31:0] model_read(int a);
      logic [31:0] v = '0;
      int w = a / 4;
      if (a % 4 != 0) return '0;
      if (w == 0) return m_ctrl;
      for (int b = 0; b < 32; b++) begin
         if (w >= 1 && w <= R)              v[b] = m_en[(R - w) * 32 + b];
         else if (w > R && w <= 2 * R)      v[b] = m_frc[(2 * R - w) * 32 + b];
         else if (w > 2 * R && w <= 3 * R)  v[b] = stat_bit((3 * R - w) * 32 + b);
         else if (w == 3 * R + 1)           v[b] = (b < NO) ? m_blk[b] : 1'b0;
         else if (w == 3 * R + 2)           v[b] = (b < NO) ? grp_bit(b) : 1'b0;
      end
      return v;
   endfunction

   task automatic model_write(int a, logic [31:0] d);
      int w = a / 4;
      if (a % 4 != 0) return;
      if (w == 0) m_ctrl = d;
      for (int b = 0; b < 32; b++) begin
         if (w >= 1 && w <= R)         m_en[(R - w) * 32 + b] = d[b];
         else if (w > R && w <= 2 * R) m_frc[(2 * R - w) * 32 + b] = d[b];
         else if (w == 3 * R + 1 && b < NO) m_blk[b] = d[b];
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = '0; m_frc = '0; m_ctrl = '0; m_blk = '0; e_out = '0; e_rd = '0;
      end else begin
         for (int j = 0; j < NO; j++) e_out[j] = m_ctrl[CH] & grp_bit(j) & ~m_blk[j];
         if (rd_en) e_rd = model_read(int'(addr));
         if (wr_en) model_write(int'(addr), wdata);
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (irq_out !== e_out) begin
            fails++;
            $display("FAIL %s irq_out actual %b expected %b at %0t", cur_req, irq_out, e_out, $time);
         end
         checks++;
         if (rdata !== e_rd) begin
            fails++;
            $display("FAIL %s rdata actual %h expected %h at %0t", cur_req, rdata, e_rd, $time);
         end
      end
   end

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk); wr_en = 1; rd_en = 0; addr = AW'(a); wdata = d;
      @(negedge clk); wr_en = 0;
   endtask
   task automatic rd(int a);
      @(negedge clk); rd_en = 1; wr_en = 0; addr = AW'(a);
      @(negedge clk); rd_en = 0;
   endtask
   task automatic rdwr(int a, logic [31:0] d);
      @(negedge clk); rd_en = 1; wr_en = 1; addr = AW'(a); wdata = d;
      @(negedge clk); rd_en = 0; wr_en = 0;
   endtask
   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      cur_req = "R1";
      for (int a = 0; a <= 4 * (3 * R + 2); a += 4) rd(a);

      cur_req = "R3";
      for (int n = 0; n < R; n++) begin
         wr(4 + 4 * n, 32'hA5000000 | n);
         wr(4 * R + 4 + 4 * n, 32'h0F0F0000 ^ (n << 4));
      end
      for (int n = 0; n < R; n++) begin rd(4 + 4 * n); rd(4 * R + 4 + 4 * n); end
      wr(12 * R + 4, 32'hFFFFFFFF); rd(12 * R + 4);
      wr(0, 32'h1234_5678); rd(0);
      wr(12 * R + 4, 0);
      for (int n = 0; n < R; n++) begin wr(4 + 4 * n, 0); wr(4 * R + 4 + 4 * n, 0); end

      cur_req = "R2";
      wr(0, 32'(1) << CH);
      wr(4 + 4 * (R - 1), 32'h0000_0020);   // input 5 in last enable word
      irq_in[5] = 1; idle(2);
      rd(8 * R + 4 + 4 * (R - 1)); rd(8 * R + 4);
      wr(4, 32'h8000_0000);                 // input NUM-1 in first word
      irq_in[NUM-1] = 1; idle(2); rd(8 * R + 4);

      cur_req = "R4";
      irq_in = '0; idle(2); rd(8 * R + 4 + 4 * (R - 1));
      wr(8 + 0, 32'hFFFF_FFFF);              // enable inputs 64..95
      wr(4 * R + 8, 32'h0000_0100);          // force input 72
      idle(2); rd(8 * R + 8);
      irq_in[72] = 1; wr(4 * R + 8, 0); idle(2); rd(8 * R + 8);
      irq_in[72] = 0; idle(2); rd(8 * R + 8);

      cur_req = "R5";
      irq_in[90] = 1; idle(3);
      irq_in[90] = 0; irq_in[5] = 1; idle(3);
      irq_in[90] = 1; idle(3);

      cur_req = "R6";
      wr(12 * R + 4, 32'h2); idle(2); rd(12 * R + 8);
      wr(12 * R + 4, 32'h3); idle(2); rd(12 * R + 8);
      wr(12 * R + 4, 32'h0); idle(2);

      cur_req = "R7";
      wr(0, 0); idle(3);
      wr(0, 32'(1) << ((CH + 1) % 32)); idle(3);
      wr(0, 32'(1) << CH); idle(3);

      cur_req = "R8";
      wr(8 * R + 4, 32'hFFFF_FFFF); rd(8 * R + 4);
      wr(12 * R + 8, 32'hFFFF_FFFF); rd(12 * R + 8);
      rd(12 * R + 12); rd(12'h100); rd(2); rd(12'hFFC);
      wr(12 * R + 12, 32'hDEAD_BEEF); rd(12 * R + 12); rd(0);

      cur_req = "R9";
      rdwr(0, 32'h0000_00FF);
      idle(3);
      rdwr(4 + 4 * (R - 1), 32'h0);
      rd(4 + 4 * (R - 1));

      cur_req = "R5";
      for (int i = 0; i < 400; i++) begin
         irq_in = {$urandom, $urandom, $urandom, $urandom};
         case ($urandom % 6)
            0: wr(4 + 4 * ($urandom % R), $urandom & $urandom);
            1: wr(4 * R + 4 + 4 * ($urandom % R), $urandom & $urandom & $urandom);
            2: wr(12 * R + 4, $urandom % 4);
            3: wr(0, ($urandom % 8 == 0) ? 32'h0 : (32'(1) << CH));
            4: rd(4 * ($urandom % (3 * R + 4)));
            default: idle(1);
         endcase
      end
      idle(2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired during %s", cur_req);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule